// File: doc/BRIEF.md
# Two-Stage Channel Chaining Trigger Router

This block sits beside the channels of a DMA engine. Its job is to make a completion event on one channel start a second channel, with no software step in between. Each channel carries two small configuration codes. The role code makes the channel a source or a destination of one of two chaining groups, or leaves it out of chaining. The trigger code on a source channel picks which level of completion fires its group: fragment, block, transaction or linked list.

The channels report their completion levels as one-cycle done pulses, one vector per level. The router matches the selected level of each group's source against that group's destination. It then issues a registered, one-cycle start pulse on the destination channel. The two groups work independently and may fire in the same cycle.

The router checks each group's role assignment as a static configuration check. A group whose roles are inconsistent raises an error flag, and its forwarding is blocked.

Top module: `chain_trigger_router`

## Requirements
- R1: Role code per channel (3 bits, channel i at bits 3i+2..3i): 0 not chained, 1 source of group 0, 2 source of group 1, 3 destination of group 0, 4 destination of group 1. Codes 5 to 7 behave like 0.
- R2: Trigger code per channel (3 bits, channel i at bits 3i+2..3i): 0 off, 1 fragment done, 2 block done, 3 transaction done, 4 linked-list done, 5 to 7 off. Only the source channel's code is used; a destination's own trigger code has no effect.
- R3: A source's selected done pulse produces a start pulse on its group's destination exactly one clock later. Each done pulse gives one start cycle, so back-to-back pulses give back-to-back starts.
- R4: Done pulses of the levels a source did not select produce no start.
- R5: Done pulses on channels that are not a valid group source (destinations, unchained channels) produce no start.
- R6: A source whose trigger code is off never forwards, whatever the level of the done pulse.
- R7: The two groups are independent. Simultaneous events start both destinations, and an event of one group never starts the other group's destination.
- R8: cfg_err[g] is high, combinationally from the role codes, when group g has more than one source, more than one destination, or a source without a destination. While it is high, group g issues no start. The other group is unaffected.
- R9: A group with a destination but no source raises no error and never starts.
- R10: While rst_n is low at a clock edge (synchronous, active low), start_pulse becomes all zero and done pulses are not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| role_cfg | input | 3*NUM_CH | Per-channel role codes |
| trig_cfg | input | 3*NUM_CH | Per-channel trigger codes |
| frag_done | input | NUM_CH | Fragment completion pulses |
| block_done | input | NUM_CH | Block completion pulses |
| xfer_done | input | NUM_CH | Transaction completion pulses |
| list_done | input | NUM_CH | Linked-list completion pulses |
| start_pulse | output | NUM_CH | Registered per-channel start pulses |
| cfg_err | output | 2 | Per-group configuration error flags |

## Verification
A start pulse is due at the first rising edge after the done pulse that causes it, so it is visible for the one cycle after the edge that sampled the event. The cfg_err flags are combinational and settle within the cycle in which the role codes change. The driver holds each stimulus for exactly one rising edge and then queues the expected start vector. The monitor pops that vector at the next falling edge, which lines every comparison up with that single register stage. Error flags are compared directly, a moment after each configuration change.

// File: rtl/chain_pkg.sv
// Shared codes and widths for the chaining trigger router.
// Assumes two chaining groups and 3-bit role and trigger codes.
package chain_pkg;
    localparam int ROLE_W     = 3;
    localparam int TRIG_W     = 3;
    localparam int NUM_GROUPS = 2;

    typedef enum logic [2:0] {
        ROLE_IDLE  = 3'd0,
        ROLE_SRC_A = 3'd1,
        ROLE_SRC_B = 3'd2,
        ROLE_DST_A = 3'd3,
        ROLE_DST_B = 3'd4
    } role_e;

    typedef enum logic [2:0] {
        TRIG_OFF   = 3'd0,
        TRIG_FRAG  = 3'd1,
        TRIG_BLOCK = 3'd2,
        TRIG_XFER  = 3'd3,
        TRIG_LIST  = 3'd4
    } trig_e;

    // Source role code of a group.
    function automatic logic [2:0] src_code(input int grp);
        return (grp == 0) ? 3'(ROLE_SRC_A) : 3'(ROLE_SRC_B);
    endfunction

    // Destination role code of a group.
    function automatic logic [2:0] dst_code(input int grp);
        return (grp == 0) ? 3'(ROLE_DST_A) : 3'(ROLE_DST_B);
    endfunction
endpackage

// File: rtl/chain_role_decode.sv
// Decodes the per-channel role codes for one chaining group.
// Produces the group's source and destination masks and its error flag.
// Assumes the role codes are quasi-static configuration.
module chain_role_decode
    import chain_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int GROUP  = 0
) (
    input  logic [NUM_CH*ROLE_W-1:0] role_cfg,
    output logic [NUM_CH-1:0]        src_mask,
    output logic [NUM_CH-1:0]        dst_mask,
    output logic                     cfg_err
);
    localparam int               CNT_W    = $clog2(NUM_CH + 1);
    localparam logic [ROLE_W-1:0] SRC_CODE = src_code(GROUP);
    localparam logic [ROLE_W-1:0] DST_CODE = dst_code(GROUP);
    localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);

    logic [CNT_W-1:0] src_cnt;
    logic [CNT_W-1:0] dst_cnt;

    // Per-channel role matches; codes outside this group's two codes leave the channel out.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_match
        assign src_mask[ch] = (role_cfg[ch*ROLE_W +: ROLE_W] == SRC_CODE);
        assign dst_mask[ch] = (role_cfg[ch*ROLE_W +: ROLE_W] == DST_CODE);
    end

    // Count the channels that hold each role of this group.
    always_comb begin
        src_cnt = '0;
        dst_cnt = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            src_cnt = src_cnt + CNT_W'(src_mask[i]);
            dst_cnt = dst_cnt + CNT_W'(dst_mask[i]);
        end
    end

    // Flag duplicated roles, or a source that has no destination.
    always_comb begin
        cfg_err = (src_cnt > ONE) || (dst_cnt > ONE) ||
                  ((src_cnt == ONE) && (dst_cnt == '0));
    end
endmodule

// File: rtl/chain_event_select.sv
// Picks, for every channel, the done level named by its trigger code.
// Codes outside 1..4 select nothing. Purely combinational.
module chain_event_select
    import chain_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH*TRIG_W-1:0] trig_cfg,
    input  logic [NUM_CH-1:0]        frag_done,
    input  logic [NUM_CH-1:0]        block_done,
    input  logic [NUM_CH-1:0]        xfer_done,
    input  logic [NUM_CH-1:0]        list_done,
    output logic [NUM_CH-1:0]        sel_evt
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sel
        logic [TRIG_W-1:0] code;
        assign code = trig_cfg[ch*TRIG_W +: TRIG_W];

        // Multiplex the chosen completion level of this channel.
        always_comb begin
            unique case (code)
                TRIG_FRAG:  sel_evt[ch] = frag_done[ch];
                TRIG_BLOCK: sel_evt[ch] = block_done[ch];
                TRIG_XFER:  sel_evt[ch] = xfer_done[ch];
                TRIG_LIST:  sel_evt[ch] = list_done[ch];
                default:    sel_evt[ch] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/chain_group_fire.sv
// Forms one group's launch mask: the destination mask when the group's
// source reports its selected event and the group is well formed.
// Assumes at most one source bit is set when cfg_err is low.
module chain_group_fire #(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] src_mask,
    input  logic [NUM_CH-1:0] dst_mask,
    input  logic [NUM_CH-1:0] sel_evt,
    input  logic              cfg_err,
    output logic [NUM_CH-1:0] launch_mask
);
    logic hit;

    // Detect the source's selected event, gated by the error flag.
    always_comb begin
        hit         = (|(src_mask & sel_evt)) && !cfg_err;
        launch_mask = hit ? dst_mask : '0;
    end
endmodule

// File: rtl/chain_trigger_router.sv
// Top of the two-stage chaining router. It decodes both groups, selects
// each channel's done level and registers the combined start pulses.
// Assumes done inputs are single-cycle pulses and the configuration is stable
// while transfers run.
module chain_trigger_router
    import chain_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*ROLE_W-1:0] role_cfg,
    input  logic [NUM_CH*TRIG_W-1:0] trig_cfg,
    input  logic [NUM_CH-1:0]        frag_done,
    input  logic [NUM_CH-1:0]        block_done,
    input  logic [NUM_CH-1:0]        xfer_done,
    input  logic [NUM_CH-1:0]        list_done,
    output logic [NUM_CH-1:0]        start_pulse,
    output logic [NUM_GROUPS-1:0]    cfg_err
);
    logic [NUM_CH-1:0] sel_evt;
    logic [NUM_CH-1:0] src_m  [NUM_GROUPS];
    logic [NUM_CH-1:0] dst_m  [NUM_GROUPS];
    logic [NUM_CH-1:0] launch [NUM_GROUPS];
    logic [NUM_CH-1:0] launch_all;
    logic [NUM_CH-1:0] dst_union;
    logic [NUM_CH-1:0] start_q;

    chain_event_select #(.NUM_CH(NUM_CH)) u_sel (
        .trig_cfg   (trig_cfg),
        .frag_done  (frag_done),
        .block_done (block_done),
        .xfer_done  (xfer_done),
        .list_done  (list_done),
        .sel_evt    (sel_evt)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        chain_role_decode #(.NUM_CH(NUM_CH), .GROUP(g)) u_dec (
            .role_cfg (role_cfg),
            .src_mask (src_m[g]),
            .dst_mask (dst_m[g]),
            .cfg_err  (cfg_err[g])
        );

        chain_group_fire #(.NUM_CH(NUM_CH)) u_fire (
            .src_mask    (src_m[g]),
            .dst_mask    (dst_m[g]),
            .sel_evt     (sel_evt),
            .cfg_err     (cfg_err[g]),
            .launch_mask (launch[g])
        );

        // R8
        err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(cfg_err[g]) |-> ((start_pulse & $past(dst_m[g])) == '0));
    end

    // Merge the group launches and the destination sets.
    always_comb begin
        launch_all = '0;
        dst_union  = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            launch_all = launch_all | launch[g];
            dst_union  = dst_union | dst_m[g];
        end
    end

    // Register the start pulses; the synchronous reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= '0;
        else        start_q <= launch_all;
    end

    assign start_pulse = start_q;

    // R3
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|start_pulse) |-> $past(|(frag_done | block_done | xfer_done | list_done)));

    // R5
    start_dst_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse & ~$past(dst_union)) == '0);

    // R7
    start_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_err) == '0) |-> ($countones(start_pulse) <= NUM_GROUPS));
endmodule

// File: tb/tb_chain_trigger_router.sv
// Scoreboard bench: the driver queues expected start vectors and the monitor compares them.
module tb_chain_trigger_router;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [3*N-1:0] role_cfg = '0;
    logic [3*N-1:0] trig_cfg = '0;
    logic [N-1:0]   frag_done = '0, block_done = '0, xfer_done = '0, list_done = '0;
    logic [N-1:0]   start_pulse;
    logic [1:0]     cfg_err;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic [N-1:0] exp;
        string        tag;
    } item_t;
    item_t q[$];
    item_t cur;

    always #2.5 clk = ~clk;

    chain_trigger_router #(.NUM_CH(N)) dut (
        .clk(clk), .rst_n(rst_n), .role_cfg(role_cfg), .trig_cfg(trig_cfg),
        .frag_done(frag_done), .block_done(block_done), .xfer_done(xfer_done),
        .list_done(list_done), .start_pulse(start_pulse), .cfg_err(cfg_err)
    );

    task automatic check(input logic [N-1:0] got, input logic [N-1:0] exp, input string tag);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: one queued expectation per falling edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            cur = q.pop_front();
            check(start_pulse, cur.exp, cur.tag);
        end
    end

    // Drive one cycle of done pulses and queue the start vector due one edge later.
    task automatic apply(input logic [N-1:0] f, b, x, l, exp, input string tag);
        @(negedge clk);
        frag_done = f; block_done = b; xfer_done = x; list_done = l;
        @(posedge clk);
        q.push_back('{exp: exp, tag: tag});
    endtask

    task automatic quiet();
        @(negedge clk);
        frag_done = '0; block_done = '0; xfer_done = '0; list_done = '0;
    endtask

    task automatic set_ch(input int ch, input logic [2:0] role, input logic [2:0] trig);
        role_cfg[3*ch +: 3] = role;
        trig_cfg[3*ch +: 3] = trig;
    endtask

    task automatic check_err(input logic [1:0] exp, input string tag);
        #1;
        check({6'b0, cfg_err}, {6'b0, exp}, tag);
    endtask

    task automatic base_cfg();
        role_cfg = '0; trig_cfg = '0;
        set_ch(0, 3'd1, 3'd1);   // group 0 source, fragment trigger
        set_ch(5, 3'd3, 3'd0);   // group 0 destination
        set_ch(2, 3'd2, 3'd2);   // group 1 source, block trigger
        set_ch(6, 3'd4, 3'd0);   // group 1 destination
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        base_cfg();
        // R10: done pulses while held in reset are not forwarded
        apply(8'h01, 0, 0, 0, 8'h00, "R10 in reset");
        quiet(); rst_n = 1'b1;
        check_err(2'b00, "R8 clean config");
        // R3: single-cycle start one edge after the source event
        apply(8'h01, 0, 0, 0, 8'h20, "R3 frag g0");
        apply(0, 0, 0, 0, 8'h00, "R3 pulse ends");
        apply(8'h01, 0, 0, 0, 8'h20, "R3 back-to-back 1");
        apply(8'h01, 0, 0, 0, 8'h20, "R3 back-to-back 2");
        // R4: unselected levels ignored
        apply(0, 8'h01, 8'h01, 8'h01, 8'h00, "R4 g0 other levels");
        apply(8'h04, 0, 8'h04, 8'h04, 8'h00, "R4 g1 other levels");
        apply(0, 8'h04, 0, 0, 8'h40, "R3 block g1");
        // R7: both groups together and no cross-talk
        apply(8'h01, 8'h04, 0, 0, 8'h60, "R7 both groups");
        apply(8'h01, 0, 0, 0, 8'h20, "R7 only g0");
        apply(0, 8'h04, 0, 0, 8'h40, "R7 only g1");
        // R5: events on destinations and unchained channels
        apply(8'hFA, 8'hFB, 8'hFF, 8'hFF, 8'h00, "R5 non-source events");
        // R2: destination trigger code has no effect; source code decides
        quiet(); set_ch(5, 3'd3, 3'd4);
        apply(0, 0, 0, 8'h01, 8'h00, "R2 dest code ignored");
        quiet(); set_ch(0, 3'd1, 3'd4);
        apply(0, 0, 0, 8'h01, 8'h20, "R2 list trigger");
        apply(8'h01, 0, 0, 0, 8'h00, "R2 frag after list select");
        quiet(); set_ch(2, 3'd2, 3'd3);
        apply(0, 0, 8'h04, 0, 8'h40, "R2 xfer trigger");
        // R6: trigger off
        quiet(); set_ch(0, 3'd1, 3'd0);
        apply(8'h01, 8'h01, 8'h01, 8'h01, 8'h00, "R6 trigger off");
        quiet(); set_ch(0, 3'd1, 3'd6);
        apply(8'h01, 8'h01, 8'h01, 8'h01, 8'h00, "R2 code 6 off");
        // R1: role code 7 is not chained
        quiet(); base_cfg(); set_ch(1, 3'd7, 3'd1);
        check_err(2'b00, "R1 role 7 no error");
        apply(8'h02, 8'h02, 8'h02, 8'h02, 8'h00, "R1 role 7 inert");
        // R8: duplicate source blocks group 0, group 1 still fires
        quiet(); base_cfg(); set_ch(3, 3'd1, 3'd1);
        check_err(2'b01, "R8 dup source");
        apply(8'h09, 8'h04, 0, 0, 8'h40, "R8 g0 blocked g1 fires");
        quiet(); base_cfg(); set_ch(5, 3'd0, 3'd0);
        check_err(2'b01, "R8 source without dest");
        apply(8'h01, 0, 0, 0, 8'h00, "R8 no dest no start");
        quiet(); base_cfg(); set_ch(7, 3'd4, 3'd0);
        check_err(2'b10, "R8 dup dest");
        apply(8'h01, 8'h04, 0, 0, 8'h20, "R8 g1 blocked g0 fires");
        // R9: destination without source
        quiet(); base_cfg(); set_ch(0, 3'd0, 3'd1);
        check_err(2'b00, "R9 no error");
        apply(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h40, "R9 g0 silent");
        // R10: synchronous reset mid-run
        quiet(); base_cfg(); rst_n = 1'b0;
        apply(8'h01, 8'h04, 0, 0, 8'h00, "R10 reset mid-run");
        quiet(); rst_n = 1'b1;
        apply(8'h01, 0, 0, 0, 8'h20, "R10 resumes");
        quiet();
        @(negedge clk);
        @(negedge clk);
        tests++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R3: got %0d pending expected 0", q.size());
        end
        finish_run();
    end
endmodule